// File: doc/BRIEF.md
# TLB Maintenance Register Interface

This block is the control-register front end through which software installs and inspects translation entries in a set-associative TLB. It has three registers on a small register bus: an entry-data register (frame number and access flags), a control register (way select, process identifier, entry-read and commit-enable bits), and a page-table address register (virtual page number field). A write to the entry-data register while commit-enable is set installs an entry. A control write with the entry-read bit set pulls an entry back into all three registers. For each register, the value software last wrote is kept apart from the value it reads back.

Entry operations are sequenced by a three-state machine. SEQ_IDLE accepts bus writes. The transition SEQ_IDLE to SEQ_COMMIT is taken on a commit-triggering data write. The transition SEQ_IDLE to SEQ_FETCH is taken on a control write with the read bit set. SEQ_COMMIT returns to SEQ_IDLE unconditionally after driving the one-cycle entry write strobe and advancing the way. SEQ_FETCH returns to SEQ_IDLE unconditionally after loading the read-back registers. The entry array lives inside the block. Its write port is brought out, so a lookup datapath can watch installs.

Top module: `tlb_maint_if`

## Requirements
- R1: Register select 0 is the entry-data register. Writing it while control bit 18 (commit-enable) reads back as 1 raises `ent_wr_stb` for exactly the next cycle. During that cycle, `ent_wr_idx` = WAY*SETS + (VPN mod SETS). WAY is control read-back bits [20 +: log2 WAYS]. VPN is bits [21:2] of the value last written to select 2.
- R2: Each commit advances the control read-back WAY field by one, modulo WAYS.
- R3: During the commit cycle, `ent_wr_valid` is 1 exactly when the VPN is below 0xC0000.
- R4: The stored entry keeps data bits [23:0] (frame number [19:0], execute 20, write 21, read 22, cacheable 23) and the global flag from bit 24. The written bits [31:25] are not stored.
- R5: A write to select 0 never changes the select 0 read-back value. With commit-enable clear, it produces no strobe.
- R6: Register select 1 is the control register. A write to it with bit 19 set reads the entry at (written WAY, latched VPN). One cycle later: select 0 reads {old bits [31:25], entry global, entry data [23:0]}, the control PID field [4 +: PID_W] holds the entry PID, and select 2 bits [21:2] hold the entry VPN.
- R7: Register select 2 is the page-table address register. A write to it updates every read-back bit except the VPN field [21:2], which keeps its previous value.
- R8: A control write with bit 19 clear is read back verbatim. The PID installed by a commit is the PID field of the last control write, even after an entry read has replaced the PID in the read-back.
- R9: After reset, all three registers read 0 and every entry reads back as all zeros.
- R10: Select 3 reads 0, and writes to it change no register.
- R11: A write that starts an entry operation completes in the following cycle, and the bus issues no write during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 2 | Register select: 0 data, 1 control, 2 page-table address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read-back of the selected register |
| ent_wr_stb | output | 1 | One-cycle entry install strobe |
| ent_wr_idx | output | log2(WAYS*SETS) | Entry index being installed |
| ent_wr_valid | output | 1 | Valid bit of the entry being installed |

## Verification
The hardest situation to reach from the ports is a commit whose PID differs from the PID currently shown in the control read-back. Reaching it takes a plain control write, then an entry read that replaces the read-back PID, and then a commit. The stimulus builds this sequence directed and then reads the new entry back. Random traffic also mixes the three registers with VPNs drawn from a small pool, so reads often land on entries written earlier with other ways and PIDs. Directed writes place VPNs on either side of 0xC0000.

// File: rtl/tlbm_pkg.sv
package tlbm_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_COMMIT = 2'd1,
        SEQ_FETCH  = 2'd2
    } seq_state_e;

    localparam logic [1:0] SEL_DATA = 2'd0;
    localparam logic [1:0] SEL_CTRL = 2'd1;
    localparam logic [1:0] SEL_PTAD = 2'd2;

    localparam int VPN_W      = 20;
    localparam int VPN_LSB    = 2;
    localparam int EDATA_W    = 24;
    localparam int GLOBAL_BIT = 24;
    localparam int PID_LSB    = 4;
    localparam int CMT_EN_BIT = 18;
    localparam int RD_BIT     = 19;
    localparam int WAY_LSB    = 20;
endpackage

// File: rtl/tlbm_store.sv
module tlbm_store #(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = 6,
    parameter int TAG_W   = 30,
    parameter int DATA_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data
);
    logic [TAG_W-1:0]  tag_q  [ENTRIES];
    logic [DATA_W-1:0] data_q [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tag_q[e]  <= '0;
                data_q[e] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(e))) begin
                tag_q[e]  <= wr_tag;
                data_q[e] <= wr_data;
            end
        end
    end

    assign rd_tag  = tag_q[rd_idx];
    assign rd_data = data_q[rd_idx];
endmodule

// File: rtl/tlbm_seq.sv
module tlbm_seq
    import tlbm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic       start_commit,
    input  logic       start_fetch,
    output logic       idle,
    output logic       commit_stb,
    output logic       fetch_stb
);
    seq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: begin
                if (start_commit)     state_d = SEQ_COMMIT;
                else if (start_fetch) state_d = SEQ_FETCH;
            end
            SEQ_COMMIT: state_d = SEQ_IDLE;
            SEQ_FETCH:  state_d = SEQ_IDLE;
            default:    state_d = SEQ_IDLE;
        endcase
    end

    always_comb begin
        idle       = (state_q == SEQ_IDLE);
        commit_stb = (state_q == SEQ_COMMIT);
        fetch_stb  = (state_q == SEQ_FETCH);
    end

    AST_STB_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        commit_stb |=> !commit_stb); // R1
    AST_BUS_QUIET_IN_OP: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |-> !reg_we); // R11
    AST_OP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_stb || fetch_stb) |=> idle); // R11
endmodule

// File: rtl/tlb_maint_if.sv
module tlb_maint_if
    import tlbm_pkg::*;
#(
    parameter int          WAYS        = 4,
    parameter int          SETS        = 16,
    parameter int          PID_W       = 8,
    parameter logic [19:0] VALID_LIMIT = 20'hC0000,
    localparam int         WAY_W       = $clog2(WAYS),
    localparam int         SET_W       = $clog2(SETS),
    localparam int         IDX_W       = WAY_W + SET_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       reg_sel,
    input  logic             reg_we,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             ent_wr_stb,
    output logic [IDX_W-1:0] ent_wr_idx,
    output logic             ent_wr_valid
);
    localparam int ENTRIES = WAYS * SETS;
    localparam int TAG_W   = VPN_W + 2 + PID_W;
    localparam int G_POS   = PID_W + 1;
    localparam int V_POS   = PID_W;

    logic [31:0]      data_rb, ctrl_rb, ptad_rb;
    logic [PID_W-1:0] pid_wr;
    logic [VPN_W-1:0] vpn_wr;

    logic [IDX_W-1:0]   pend_idx, fetch_idx;
    logic [TAG_W-1:0]   pend_tag, rd_tag;
    logic [EDATA_W-1:0] pend_data, rd_data;

    logic seq_idle, commit_stb, fetch_stb;
    logic wr_data_reg, wr_ctrl_reg, wr_ptad_reg;
    logic start_commit, start_fetch;

    logic [WAY_W-1:0] ctrl_way;
    logic [SET_W-1:0] vpn_set;
    logic             new_valid;

    assign wr_data_reg  = seq_idle && reg_we && (reg_sel == SEL_DATA);
    assign wr_ctrl_reg  = seq_idle && reg_we && (reg_sel == SEL_CTRL);
    assign wr_ptad_reg  = seq_idle && reg_we && (reg_sel == SEL_PTAD);
    assign start_commit = wr_data_reg && ctrl_rb[CMT_EN_BIT];
    assign start_fetch  = wr_ctrl_reg && reg_wdata[RD_BIT];

    assign ctrl_way  = ctrl_rb[WAY_LSB +: WAY_W];
    assign vpn_set   = vpn_wr[SET_W-1:0];
    assign new_valid = (vpn_wr < VALID_LIMIT);

    tlbm_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_we       (reg_we),
        .start_commit (start_commit),
        .start_fetch  (start_fetch),
        .idle         (seq_idle),
        .commit_stb   (commit_stb),
        .fetch_stb    (fetch_stb)
    );

    tlbm_store #(
        .ENTRIES (ENTRIES),
        .IDX_W   (IDX_W),
        .TAG_W   (TAG_W),
        .DATA_W  (EDATA_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (commit_stb),
        .wr_idx  (pend_idx),
        .wr_tag  (pend_tag),
        .wr_data (pend_data),
        .rd_idx  (fetch_idx),
        .rd_tag  (rd_tag),
        .rd_data (rd_data)
    );

    // Operation staging: index, tag and data captured in the triggering cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_idx  <= '0;
            pend_tag  <= '0;
            pend_data <= '0;
            fetch_idx <= '0;
        end else begin
            if (start_commit) begin
                pend_idx  <= {ctrl_way, vpn_set};
                pend_tag  <= {vpn_wr, reg_wdata[GLOBAL_BIT], new_valid, pid_wr};
                pend_data <= reg_wdata[EDATA_W-1:0];
            end
            if (start_fetch) begin
                fetch_idx <= {reg_wdata[WAY_LSB +: WAY_W], vpn_set};
            end
        end
    end

    // Written-value latches and read-back registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_rb <= '0;
            ctrl_rb <= '0;
            ptad_rb <= '0;
            pid_wr  <= '0;
            vpn_wr  <= '0;
        end else begin
            if (wr_ctrl_reg) begin
                ctrl_rb <= reg_wdata;
                pid_wr  <= reg_wdata[PID_LSB +: PID_W];
            end
            if (wr_ptad_reg) begin
                vpn_wr  <= reg_wdata[VPN_LSB +: VPN_W];
                ptad_rb <= {reg_wdata[31:VPN_LSB+VPN_W],
                            ptad_rb[VPN_LSB +: VPN_W],
                            reg_wdata[VPN_LSB-1:0]};
            end
            if (commit_stb) begin
                ctrl_rb[WAY_LSB +: WAY_W] <= ctrl_way + 1'b1;
            end
            if (fetch_stb) begin
                data_rb <= {data_rb[31:GLOBAL_BIT+1], rd_tag[G_POS], rd_data};
                ctrl_rb[PID_LSB +: PID_W] <= rd_tag[PID_W-1:0];
                ptad_rb[VPN_LSB +: VPN_W] <= rd_tag[TAG_W-1 -: VPN_W];
            end
        end
    end

    always_comb begin
        unique case (reg_sel)
            SEL_DATA: reg_rdata = data_rb;
            SEL_CTRL: reg_rdata = ctrl_rb;
            SEL_PTAD: reg_rdata = ptad_rb;
            default:  reg_rdata = '0;
        endcase
    end

    assign ent_wr_stb   = commit_stb;
    assign ent_wr_idx   = pend_idx;
    assign ent_wr_valid = pend_tag[V_POS];

    AST_WAY_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        commit_stb |=> (ctrl_rb[WAY_LSB +: WAY_W] == WAY_W'($past(ctrl_way) + 1'b1))); // R2
    AST_DATA_RB_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data_reg |=> $stable(data_rb)); // R5
    AST_PTAD_VPN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ptad_reg |=> $stable(ptad_rb[VPN_LSB +: VPN_W])); // R7
    AST_NO_STB_WITHOUT_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data_reg && !ctrl_rb[CMT_EN_BIT]) |=> !ent_wr_stb); // R5
endmodule

// File: tb/tb_tlb_maint_if.sv
module tb_tlb_maint_if;
    localparam int WAYS = 4;
    localparam int SETS = 16;
    localparam int ENT  = WAYS * SETS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ent_wr_stb;
    logic [5:0]  ent_wr_idx;
    logic        ent_wr_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference state
    logic [31:0] m_data, m_ctrl, m_ptad;
    logic [7:0]  m_pidw;
    logic [19:0] m_vpnw;
    logic [19:0] e_vpn  [ENT];
    logic        e_g    [ENT];
    logic [7:0]  e_pid  [ENT];
    logic [23:0] e_data [ENT];

    tlb_maint_if dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ent_wr_stb(ent_wr_stb),
        .ent_wr_idx(ent_wr_idx), .ent_wr_valid(ent_wr_valid)
    );

    always #5 clk = ~clk;

    initial begin
        for (int c = 0; c < 60000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    function automatic int idx_of(input logic [1:0] way, input logic [19:0] vpn);
        return int'(way) * SETS + int'(vpn[3:0]);
    endfunction

    task automatic read_reg(input logic [1:0] s, output logic [31:0] v);
        reg_sel = s;
        #1;
        v = reg_rdata;
    endtask

    task automatic check_regs(input string req);
        logic [31:0] v;
        read_reg(2'd0, v); chk({req, " data"}, v, m_data);
        read_reg(2'd1, v); chk({req, " ctrl"}, v, m_ctrl);
        read_reg(2'd2, v); chk({req, " ptad"}, v, m_ptad);
    endtask

    // One bus write, then one quiet cycle (R11); model updated from the requirements
    task automatic bus_write(input logic [1:0] s, input logic [31:0] v, input string req);
        bit          exp_cmt;
        int          ix;
        logic [19:0] cvpn;
        exp_cmt = (s == 2'd0) && m_ctrl[18];
        ix   = idx_of(m_ctrl[21:20], m_vpnw);
        cvpn = m_vpnw;
        @(negedge clk);
        reg_sel = s; reg_we = 1'b1; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
        chk({req, " R1 stb"}, 32'(ent_wr_stb), 32'(exp_cmt));
        if (exp_cmt) begin
            chk({req, " R1 idx"}, 32'(ent_wr_idx), 32'(ix));
            chk({req, " R3 valid"}, 32'(ent_wr_valid), 32'(cvpn < 20'hC0000));
        end
        @(negedge clk);
        chk({req, " R11 stb low"}, 32'(ent_wr_stb), 32'd0);
        unique case (s)
            2'd0: if (exp_cmt) begin
                e_vpn[ix] = cvpn; e_g[ix] = v[24]; e_pid[ix] = m_pidw;
                e_data[ix] = v[23:0];
                m_ctrl[21:20] = m_ctrl[21:20] + 2'd1;
            end
            2'd1: begin
                m_ctrl = v; m_pidw = v[11:4];
                if (v[19]) begin
                    ix = idx_of(v[21:20], m_vpnw);
                    m_data = {m_data[31:25], e_g[ix], e_data[ix]};
                    m_ctrl[11:4] = e_pid[ix];
                    m_ptad[21:2] = e_vpn[ix];
                end
            end
            2'd2: begin
                m_vpnw = v[21:2];
                m_ptad = {v[31:22], m_ptad[21:2], v[1:0]};
            end
            default: ;
        endcase
        check_regs(req);
    endtask

    function automatic logic [31:0] ctrl_val(input logic [1:0] way, input logic rd,
                                             input logic en, input logic [7:0] pid);
        return {10'd0, way, rd, en, 6'd0, pid, 4'd0};
    endfunction

    function automatic logic [31:0] ptad_val(input logic [19:0] vpn);
        return {10'h2A5, vpn, 2'b01};
    endfunction

    initial begin
        logic [19:0] pool [6];
        logic [31:0] v;
        for (int i = 0; i < ENT; i++) begin
            e_vpn[i] = '0; e_g[i] = 1'b0; e_pid[i] = '0; e_data[i] = '0;
        end
        m_data = '0; m_ctrl = '0; m_ptad = '0; m_pidw = '0; m_vpnw = '0;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_regs("R9 reset");
        read_reg(2'd3, v); chk("R10 sel3 read", v, 32'd0);
        // entry read straight after reset shows zeros
        bus_write(2'd1, ctrl_val(2'd3, 1'b1, 1'b0, 8'h00), "R9 entry zero");

        // boundary VPNs around the valid limit, commit-enable on
        bus_write(2'd1, ctrl_val(2'd0, 1'b0, 1'b1, 8'h5A), "R8 plain ctrl");
        bus_write(2'd2, ptad_val(20'hBFFFF), "R7 ptad");
        bus_write(2'd0, 32'hFFFF_FFFF, "R3 below limit R4 R5");
        bus_write(2'd2, ptad_val(20'hC0000), "R7 ptad 2");
        bus_write(2'd0, 32'h0012_3456, "R3 at limit");
        bus_write(2'd0, 32'h0100_0001, "R2 way step");
        bus_write(2'd0, 32'h00F0_0002, "R2 way wrap");
        bus_write(2'd0, 32'h0000_0003, "R2 after wrap");
        // read back the BFFFF entry (way 0)
        bus_write(2'd2, ptad_val(20'hBFFFF), "R7 ptad 3");
        bus_write(2'd1, ctrl_val(2'd0, 1'b1, 1'b1, 8'h11), "R6 fetch global");
        // PID source stays the last written ctrl value, not the fetched PID
        bus_write(2'd1, ctrl_val(2'd2, 1'b0, 1'b1, 8'hC3), "R8 pid src");
        bus_write(2'd1, ctrl_val(2'd0, 1'b1, 1'b1, 8'h77), "R8 fetch replaces pid");
        bus_write(2'd0, 32'h00AB_CDEF, "R8 commit pid");
        bus_write(2'd1, ctrl_val(2'd0, 1'b1, 1'b0, 8'h00), "R8 readback pid");
        // commit-enable clear: no install
        bus_write(2'd0, 32'hDEAD_BEEF, "R5 no enable");
        bus_write(2'd3, 32'hFFFF_FFFF, "R10 sel3 write");
        read_reg(2'd3, v); chk("R10 sel3 read after", v, 32'd0);

        for (int i = 0; i < 6; i++) pool[i] = {$urandom_range(0, 15) == 0 ? 4'hC : 4'h1, 12'h000, 4'(i * 3)};
        for (int n = 0; n < 400; n++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op < 4)
                bus_write(2'd0, $urandom, "R1 R4 R5 rnd");
            else if (op < 7)
                bus_write(2'd1, ctrl_val(2'($urandom), 1'($urandom), ($urandom_range(0, 3) != 0),
                                         8'($urandom)) | ($urandom & 32'hFC03_F00F),
                          "R6 R8 rnd");
            else if (op < 9)
                bus_write(2'd2, {10'($urandom), pool[$urandom_range(0, 5)], 2'($urandom)}, "R7 rnd");
            else
                bus_write(2'd3, $urandom, "R10 rnd");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule